// File: doc/BRIEF.md
# Processor Interrupt Delivery Controller

This block sits between the interrupt sources of a system and one processor core. It holds three kinds of request until they are serviced: a reset request, a non-maskable request, and a maskable request. The maskable request is carried as a 6-bit priority-level vector that is written through a strobe. At each instruction boundary that the core signals, the block picks the request with the highest priority and services it. It raises at most one exception request pulse per boundary.

Reset and non-maskable requests share one exception output. A maskable level is copied into the hardware-interrupt field of a cause word each time it is serviced. It is taken only when the core's status word has its global-enable bit set and at least one level bit falls inside the status mask field. A level that is not taken stays pending and is tried again at every later boundary. A strobe that carries zero withdraws the level. The next service then clears the cause field and raises no exception.

Top module: `irq_dlv_ctrl`

## Requirements
- R1: A synchronous block reset (`rst` high) clears every pending request, the withdrawn marker and the cause field, and holds both exception outputs low. No exception follows at the first boundary after the reset is released.
- R2: A one-cycle pulse on `rst_req_i` or `nmi_req_i` makes `nmirst_exc_o` high for exactly one cycle, in the cycle after the clock edge that samples the next `boundary_i`.
- R3: When several requests are pending, one boundary services only one of them: the reset request first, then the non-maskable request, then the maskable level. The two exception outputs are never high together.
- R4: Nothing is serviced and no exception is raised while `boundary_i` is low. Pending requests are held.
- R5: A level strobe with a nonzero value replaces any earlier pending level or withdrawn state.
- R6: When the maskable level is serviced, the cause field at bits [CAUSE_SHIFT+5:CAUSE_SHIFT] of `cause_o` takes the pending level. Every bit outside that field is always zero.
- R7: A serviced level raises `int_exc_o` for one cycle and is then cleared, but only when bit IE_BIT of `status_i` is 1 and the level ANDed with `status_i[IM_SHIFT+5:IM_SHIFT]` is nonzero.
- R8: A level that fails the condition of R7 stays pending. It is tried again at every later boundary, with the status value of that cycle, until it is taken or withdrawn.
- R9: A level strobe with the value zero marks the level withdrawn. At its service the cause field becomes zero, no exception is raised and the marker is dropped, so later boundaries raise nothing.
- R10: The cause field changes only when a maskable level or withdrawal is serviced. It keeps its value while reset or non-maskable requests are serviced, and when no request is pending.
- R11: A new request that arrives in the same cycle as the service of the same source wins: the request stays pending and is serviced again at the next boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_req_i | input | 1 | Reset request pulse |
| nmi_req_i | input | 1 | Non-maskable request pulse |
| lvl_strobe_i | input | 1 | Level write strobe |
| lvl_i | input | 6 | Maskable level vector; zero withdraws |
| status_i | input | STAT_W | Core status word (enable bit and mask field) |
| boundary_i | input | 1 | Instruction boundary strobe |
| nmirst_exc_o | output | 1 | Reset / non-maskable exception request pulse |
| int_exc_o | output | 1 | Maskable interrupt exception request pulse |
| cause_o | output | STAT_W | Cause word holding the hardware-interrupt field |

## Verification
The bench builds the block with a 32-bit status word, the enable bit at 0, the mask field moved to bit 16 and the cause field moved to bit 4. Neither field is at its default position, so a wrong shift or a field that overlaps another shows up as a cause mismatch or as a missed or spurious take. The cause word is compared in full, so any bit set outside the field is caught. Masking, disabling, withdrawing and overwriting the level are each tried against boundaries where the status changes between attempts.

// File: rtl/irq_dlv_pkg.sv
package irq_dlv_pkg;

    localparam int IPL_W   = 6;
    localparam int NUM_SRC = 2;
    localparam int SRC_RST = 0;
    localparam int SRC_NMI = 1;

    typedef logic [IPL_W-1:0] ipl_t;

    // Maskable level tracking state
    typedef enum logic [1:0] {
        LV_IDLE      = 2'd0,
        LV_WITHDRAWN = 2'd1,
        LV_ARMED     = 2'd2
    } lvl_state_e;

    typedef struct packed {
        lvl_state_e state;
        ipl_t       ipl;
    } lvl_rec_t;

    // Decision taken at an instruction boundary
    typedef enum logic [2:0] {
        SVC_NONE = 3'd0,
        SVC_RST  = 3'd1,
        SVC_NMI  = 3'd2,
        SVC_DROP = 3'd3,
        SVC_TAKE = 3'd4,
        SVC_HOLD = 3'd5
    } svc_e;

    function automatic logic ipl_hit(input ipl_t lvl, input ipl_t mask);
        return |(lvl & mask);
    endfunction

endpackage

// File: rtl/irq_req_flag.sv
module irq_req_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic pend_o
);
    // A new request outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (rst)
            pend_o <= 1'b0;
        else if (set_i)
            pend_o <= 1'b1;
        else if (clr_i)
            pend_o <= 1'b0;
    end
endmodule

// File: rtl/irq_lvl_track.sv
module irq_lvl_track
    import irq_dlv_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     strobe_i,
    input  ipl_t     ipl_i,
    input  logic     consume_i,
    output lvl_rec_t rec_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rec_o.state <= LV_IDLE;
            rec_o.ipl   <= '0;
        end else if (strobe_i) begin
            rec_o.state <= (ipl_i == '0) ? LV_WITHDRAWN : LV_ARMED;
            rec_o.ipl   <= ipl_i;
        end else if (consume_i) begin
            rec_o.state <= LV_IDLE;
            rec_o.ipl   <= '0;
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
    import irq_dlv_pkg::*;
#(
    parameter int STAT_W   = 32,
    parameter int IE_BIT   = 0,
    parameter int IM_SHIFT = 10
) (
    input  logic              rst_pend_i,
    input  logic              nmi_pend_i,
    input  lvl_rec_t          rec_i,
    input  logic [STAT_W-1:0] status_i,
    output svc_e              svc_o
);
    logic gate_en;
    ipl_t gate_mask;

    assign gate_en   = status_i[IE_BIT];
    assign gate_mask = status_i[IM_SHIFT +: IPL_W];

    always_comb begin
        if (rst_pend_i)
            svc_o = SVC_RST;
        else if (nmi_pend_i)
            svc_o = SVC_NMI;
        else begin
            unique case (rec_i.state)
                LV_WITHDRAWN: svc_o = SVC_DROP;
                LV_ARMED:     svc_o = (gate_en && ipl_hit(rec_i.ipl, gate_mask))
                                      ? SVC_TAKE : SVC_HOLD;
                default:      svc_o = SVC_NONE;
            endcase
        end
    end
endmodule

// File: rtl/irq_dlv_ctrl.sv
module irq_dlv_ctrl
    import irq_dlv_pkg::*;
#(
    parameter int STAT_W      = 32,
    parameter int IE_BIT      = 0,
    parameter int IM_SHIFT    = 10,
    parameter int CAUSE_SHIFT = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_req_i,
    input  logic              nmi_req_i,
    input  logic              lvl_strobe_i,
    input  logic [5:0]        lvl_i,
    input  logic [STAT_W-1:0] status_i,
    input  logic              boundary_i,
    output logic              nmirst_exc_o,
    output logic              int_exc_o,
    output logic [STAT_W-1:0] cause_o
);
    localparam int PAD_W = STAT_W - IPL_W;

    logic [NUM_SRC-1:0] req_set;
    logic [NUM_SRC-1:0] req_clr;
    logic [NUM_SRC-1:0] req_pend;
    lvl_rec_t           lvl_rec;
    logic               lvl_consume;
    svc_e               svc_sel;
    svc_e               svc_act;
    ipl_t               cause_ipl_q;

    assign req_set[SRC_RST] = rst_req_i;
    assign req_set[SRC_NMI] = nmi_req_i;

    // One pending flag per edge-type request source
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        irq_req_flag u_flag (
            .clk    (clk),
            .rst    (rst),
            .set_i  (req_set[g]),
            .clr_i  (req_clr[g]),
            .pend_o (req_pend[g])
        );
    end

    irq_lvl_track u_lvl (
        .clk       (clk),
        .rst       (rst),
        .strobe_i  (lvl_strobe_i),
        .ipl_i     (lvl_i),
        .consume_i (lvl_consume),
        .rec_o     (lvl_rec)
    );

    irq_arbiter #(
        .STAT_W   (STAT_W),
        .IE_BIT   (IE_BIT),
        .IM_SHIFT (IM_SHIFT)
    ) u_arb (
        .rst_pend_i (req_pend[SRC_RST]),
        .nmi_pend_i (req_pend[SRC_NMI]),
        .rec_i      (lvl_rec),
        .status_i   (status_i),
        .svc_o      (svc_sel)
    );

    // Decisions act only on an instruction boundary
    assign svc_act = boundary_i ? svc_sel : SVC_NONE;

    always_comb begin
        req_clr          = '0;
        req_clr[SRC_RST] = (svc_act == SVC_RST);
        req_clr[SRC_NMI] = (svc_act == SVC_NMI);
        lvl_consume      = (svc_act == SVC_DROP) || (svc_act == SVC_TAKE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_ipl_q  <= '0;
            nmirst_exc_o <= 1'b0;
            int_exc_o    <= 1'b0;
        end else begin
            nmirst_exc_o <= (svc_act == SVC_RST) || (svc_act == SVC_NMI);
            int_exc_o    <= (svc_act == SVC_TAKE);
            unique case (svc_act)
                SVC_DROP:          cause_ipl_q <= '0;
                SVC_TAKE, SVC_HOLD: cause_ipl_q <= lvl_rec.ipl;
                default:           cause_ipl_q <= cause_ipl_q;
            endcase
        end
    end

    assign cause_o = {{PAD_W{1'b0}}, cause_ipl_q} << CAUSE_SHIFT;

endmodule

// File: rtl/irq_dlv_ctrl_chk.sv
module irq_dlv_ctrl_chk #(
    parameter int STAT_W      = 32,
    parameter int IE_BIT      = 0,
    parameter int IM_SHIFT    = 10,
    parameter int CAUSE_SHIFT = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              boundary_i,
    input logic [STAT_W-1:0] status_i,
    input logic              nmirst_exc_o,
    input logic              int_exc_o,
    input logic [STAT_W-1:0] cause_o
);
    logic live;
    always_ff @(posedge clk) begin
        if (rst) live <= 1'b0;
        else     live <= 1'b1;
    end

    assert_one_exc_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({nmirst_exc_o, int_exc_o}));

    assert_boundary_only_R4: assert property (@(posedge clk) disable iff (rst)
        (live && (nmirst_exc_o || int_exc_o)) |-> $past(boundary_i));

    assert_take_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (live && int_exc_o) |->
            ($past(status_i[IE_BIT]) &&
             (|(cause_o[CAUSE_SHIFT +: 6] & $past(status_i[IM_SHIFT +: 6])))));

    assert_cause_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (live && !$past(boundary_i)) |-> $stable(cause_o));

    assert_nmirst_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        (nmirst_exc_o && !boundary_i) |=> !nmirst_exc_o);

    assert_int_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (int_exc_o && !boundary_i) |=> !int_exc_o);
endmodule

bind irq_dlv_ctrl irq_dlv_ctrl_chk #(
    .STAT_W      (STAT_W),
    .IE_BIT      (IE_BIT),
    .IM_SHIFT    (IM_SHIFT),
    .CAUSE_SHIFT (CAUSE_SHIFT)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .boundary_i   (boundary_i),
    .status_i     (status_i),
    .nmirst_exc_o (nmirst_exc_o),
    .int_exc_o    (int_exc_o),
    .cause_o      (cause_o)
);

// File: tb/irq_dlv_ctrl_bench.sv
`timescale 1ns/1ps
module irq_dlv_ctrl_bench;
    localparam int SW  = 32;
    localparam int IEB = 0;
    localparam int IMS = 16;
    localparam int CS  = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          rst_req_i, nmi_req_i, lvl_strobe_i, boundary_i;
    logic [5:0]    lvl_i;
    logic [SW-1:0] status_i;
    logic          nmirst_exc_o, int_exc_o;
    logic [SW-1:0] cause_o;

    always #2 clk = ~clk;

    irq_dlv_ctrl #(
        .STAT_W(SW), .IE_BIT(IEB), .IM_SHIFT(IMS), .CAUSE_SHIFT(CS)
    ) u_irq_dlv_ctrl (
        .clk(clk), .rst(rst), .rst_req_i(rst_req_i), .nmi_req_i(nmi_req_i),
        .lvl_strobe_i(lvl_strobe_i), .lvl_i(lvl_i), .status_i(status_i),
        .boundary_i(boundary_i), .nmirst_exc_o(nmirst_exc_o),
        .int_exc_o(int_exc_o), .cause_o(cause_o)
    );

    typedef struct {
        bit         is_int;
        logic [5:0] ipl;
        string      tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_fail   = 0;

    function automatic logic [SW-1:0] stat(input bit ie, input logic [5:0] im);
        logic [SW-1:0] w;
        w = '0;
        w[IEB] = ie;
        w[IMS +: 6] = im;
        return w;
    endfunction

    function automatic logic [SW-1:0] cword(input logic [5:0] ipl);
        logic [SW-1:0] w;
        w = '0;
        w[CS +: 6] = ipl;
        return w;
    endfunction

    task automatic check(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor: every exception pulse must match the head of the queue
    always @(negedge clk) begin
        if (!rst && (nmirst_exc_o || int_exc_o)) begin
            n_checks++;
            if (q.size() == 0) begin
                n_fail++;
                $display("FAIL R3 unexpected exception: actual nmirst=%b int=%b expected none",
                         nmirst_exc_o, int_exc_o);
            end else begin
                exp_t e;
                e = q.pop_front();
                if (nmirst_exc_o && int_exc_o) begin
                    n_fail++;
                    $display("FAIL R3 %s: actual both outputs high expected one", e.tag);
                end else if (e.is_int != int_exc_o) begin
                    n_fail++;
                    $display("FAIL %s: actual int=%b expected int=%b", e.tag, int_exc_o, e.is_int);
                end else if (e.is_int && cause_o !== cword(e.ipl)) begin
                    n_fail++;
                    $display("FAIL %s: actual cause %h expected %h", e.tag, cause_o, cword(e.ipl));
                end
            end
        end
    end

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic boundary;
        boundary_i = 1'b1;
        tick();
        boundary_i = 1'b0;
    endtask

    task automatic pulse_nmi;
        nmi_req_i = 1'b1; tick(); nmi_req_i = 1'b0;
    endtask

    task automatic put_lvl(input logic [5:0] v);
        lvl_i = v; lvl_strobe_i = 1'b1; tick(); lvl_strobe_i = 1'b0;
    endtask

    task automatic expect_nmirst(input string tag);
        exp_t e;
        e.is_int = 1'b0; e.ipl = '0; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic expect_int(input logic [5:0] ipl, input string tag);
        exp_t e;
        e.is_int = 1'b1; e.ipl = ipl; e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; rst_req_i = 0; nmi_req_i = 0; lvl_strobe_i = 0;
        boundary_i = 0; lvl_i = '0; status_i = '0;
        repeat (3) tick();
        check("R1 reset cause", cause_o, '0);
        check("R1 reset outputs", {31'b0, nmirst_exc_o | int_exc_o}, '0);
        rst = 1'b0;
        tick();

        // R2: single NMI, one-cycle pulse after the boundary
        pulse_nmi();
        expect_nmirst("R2 nmi delivered");
        boundary();
        check("R2 nmirst high", {31'b0, nmirst_exc_o}, 1);
        tick();
        check("R2 one-cycle pulse", {31'b0, nmirst_exc_o}, 0);

        // R4: pending held without a boundary
        pulse_nmi();
        repeat (5) tick();
        check("R4 no exc without boundary", {31'b0, nmirst_exc_o | int_exc_o}, 0);
        expect_nmirst("R4 held nmi delivered");
        boundary();
        tick();

        // R3: all three at once, priority order, one per boundary; R10 cause kept
        status_i = stat(1'b1, 6'h3F);
        rst_req_i = 1; nmi_req_i = 1; lvl_i = 6'h05; lvl_strobe_i = 1;
        tick();
        rst_req_i = 0; nmi_req_i = 0; lvl_strobe_i = 0;
        expect_nmirst("R3 reset first");
        boundary();
        check("R10 cause kept on reset service", cause_o, '0);
        expect_nmirst("R3 nmi second");
        boundary();
        check("R10 cause kept on nmi service", cause_o, '0);
        expect_int(6'h05, "R3 level last");
        boundary();
        check("R6 cause field", cause_o, cword(6'h05));
        tick();
        boundary();
        check("R10 cause kept when idle", cause_o, cword(6'h05));

        // R8: masked level kept and retried
        status_i = stat(1'b1, 6'h02);
        put_lvl(6'h04);
        boundary();
        check("R8 masked cause", cause_o, cword(6'h04));
        check("R8 masked no exc", {31'b0, int_exc_o}, 0);
        for (int i = 0; i < 3; i++) begin
            tick();
            boundary();
        end
        check("R8 still no exc", {31'b0, int_exc_o}, 0);
        status_i = stat(1'b1, 6'h04);
        expect_int(6'h04, "R8 retried and taken");
        boundary();
        check("R7 taken after unmask", {31'b0, int_exc_o}, 1);

        // R7: global enable off blocks, then on delivers
        tick();
        status_i = stat(1'b0, 6'h3F);
        put_lvl(6'h01);
        boundary();
        check("R7 disabled no exc", {31'b0, int_exc_o}, 0);
        status_i = stat(1'b1, 6'h3F);
        expect_int(6'h01, "R7 enabled take");
        boundary();

        // R9: withdrawal clears cause and raises nothing
        tick();
        status_i = stat(1'b1, 6'h00);
        put_lvl(6'h08);
        boundary();
        check("R9 cause before withdraw", cause_o, cword(6'h08));
        put_lvl(6'h00);
        boundary();
        check("R9 cause cleared", cause_o, '0);
        check("R9 no exc", {31'b0, int_exc_o}, 0);
        status_i = stat(1'b1, 6'h3F);
        boundary();
        check("R9 dropped, no later exc", {31'b0, int_exc_o}, 0);

        // R5: nonzero strobe overwrites
        status_i = stat(1'b1, 6'h20);
        put_lvl(6'h10);
        put_lvl(6'h20);
        expect_int(6'h20, "R5 overwrite taken");
        boundary();
        check("R5 cause new level", cause_o, cword(6'h20));

        // R11: same-cycle new NMI outranks its service
        tick();
        pulse_nmi();
        expect_nmirst("R11 first service");
        nmi_req_i = 1; boundary_i = 1;
        tick();
        nmi_req_i = 0; boundary_i = 0;
        expect_nmirst("R11 re-request serviced");
        boundary();
        tick();

        // R1: block reset discards pending work
        status_i = stat(1'b1, 6'h3F);
        pulse_nmi();
        put_lvl(6'h03);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        tick();
        check("R1 cause cleared by block reset", cause_o, '0);
        boundary();
        check("R1 nothing after block reset", {31'b0, nmirst_exc_o | int_exc_o}, 0);

        repeat (4) tick();
        check("R3 scoreboard drained", q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule